// File: doc/BRIEF.md
# Stream-to-Memory Write Engine

This block moves one packet, or one fixed-size piece of a stream, into memory. A host hands it a descriptor made of a base address, a byte length and a 32-bit control word. The engine then accepts 32-bit stream beats and turns each accepted beat into a single-beat memory write. The address starts at the base and rises by 4 after every beat. The transfer ends on one of two conditions, chosen by the control word: the programmed byte length has been reached, or an end-of-packet beat has arrived.

While a transfer runs, the engine ORs the 8-bit stream error vector of every accepted beat into a sticky record. When the transfer finishes, it pulses a done strobe and shows the number of bytes written. It can then raise up to three sticky interrupts, each enabled by the descriptor: transfer complete, masked stream error, and overrun (more data than the length with no end-of-packet seen). The host clears the interrupts with a one-cycle pulse.

The controller has three states. IDLE waits for a descriptor and goes to RUN when it is accepted (transition LOAD). RUN writes beats; it stays in RUN (transition BEAT) until the last beat is accepted, then goes to DONE (transition FINISH). DONE lasts one cycle and returns to IDLE (transition RETIRE).

Top module: `s2m_write_engine`

## Requirements
- R1: After reset the engine is in IDLE with desc_ready=1, st_ready=0, mem_wr=0, done_pulse=0, done_bytes=0, and all three interrupts at 0.
- R2: In RUN, st_ready equals !mem_wait. mem_wr equals st_valid. A beat is accepted when st_valid and st_ready are both 1. The k-th accepted beat (k from 0) is written with mem_addr = base + 4*k and mem_wdata = st_data.
- R3: With control bit 12 at 0 (length mode), the transfer ends on the accepted beat that brings the byte count (4 per beat) to at least the length; a length of 0 ends after one beat. st_eop has no effect.
- R4: With control bit 12 at 1 (packet mode), the transfer ends on the accepted beat with st_eop=1, whatever the length.
- R5: done_pulse is 1 for exactly the one cycle after the last beat. From that cycle on, done_bytes equals 4 times the number of beats accepted, until the next descriptor is accepted.
- R6: st_err is ORed over accepted beats only, and the record is cleared when a descriptor is accepted. irq_err is set at completion if any recorded bit has its mask bit in control bits 23:16 at 1.
- R7: irq_done is set at completion when control bit 14 is 1.
- R8: irq_early is set at completion when control bit 15 is 1, packet mode is on, and an accepted beat with st_eop=0 brought the byte count above the length.
- R9: Interrupts are set in the cycle after done_pulse and stay set until irq_clr is 1. irq_clr clears them one cycle later. When a set and a clear fall in the same cycle, the set wins.
- R10: A descriptor is accepted only in IDLE. desc_ready is 0 during RUN and DONE, and desc_valid has no effect there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| desc_valid | input | 1 | Descriptor offered |
| desc_ready | output | 1 | Engine idle, descriptor taken this cycle |
| desc_addr | input | 32 | Destination base address |
| desc_len | input | 16 | Transfer length in bytes |
| desc_ctrl | input | 32 | Control word (bits 12, 14, 15, 23:16 used) |
| st_valid | input | 1 | Stream beat valid |
| st_ready | output | 1 | Engine can take a beat |
| st_data | input | 32 | Stream beat data |
| st_eop | input | 1 | Last beat of packet |
| st_err | input | 8 | Stream error bits for this beat |
| mem_wr | output | 1 | Memory write request |
| mem_wait | input | 1 | Memory stalls the request |
| mem_addr | output | 32 | Write address |
| mem_wdata | output | 32 | Write data |
| done_pulse | output | 1 | One-cycle completion strobe |
| done_bytes | output | 16 | Bytes written by the last transfer |
| irq_clr | input | 1 | Clears all interrupts |
| irq_done | output | 1 | Transfer complete interrupt |
| irq_err | output | 1 | Masked stream error interrupt |
| irq_early | output | 1 | Overrun without end-of-packet interrupt |

## Verification
The write request, address and data follow the stream inputs in the same cycle. The bench checks them a quarter period after the falling edge on which the inputs were driven. done_pulse and done_bytes are due in the first cycle after the edge that takes the last beat, and the interrupts one cycle after that. A clear shows one cycle after the irq_clr pulse. The bench samples each of these at that exact offset and never waits for them to appear. Stray descriptors and stray end-of-packet flags are injected while the engine is busy; their lack of effect shows in the checked write addresses and in the byte count.

// File: rtl/s2m_pkg.sv
package s2m_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } state_t;

    localparam int CTRL_EOP_MODE = 12;
    localparam int CTRL_DONE_EN  = 14;
    localparam int CTRL_EARLY_EN = 15;
    localparam int CTRL_MASK_LO  = 16;

    localparam int IRQ_N     = 3;
    localparam int IRQ_DONE  = 0;
    localparam int IRQ_ERR   = 1;
    localparam int IRQ_EARLY = 2;
endpackage

// File: rtl/s2m_beat_track.sv
module s2m_beat_track #(
    parameter int AW   = 32,
    parameter int LW   = 16,
    parameter int STEP = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] base,
    input  logic          beat,
    output logic [AW-1:0] addr_o,
    output logic [LW-1:0] count_o,
    output logic [LW-1:0] count_nxt_o
);
    localparam logic [AW-1:0] A_STEP = AW'(STEP);
    localparam logic [LW-1:0] C_STEP = LW'(STEP);

    assign count_nxt_o = count_o + C_STEP;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_o  <= '0;
            count_o <= '0;
        end else if (load) begin
            addr_o  <= base;
            count_o <= '0;
        end else if (beat) begin
            addr_o  <= addr_o + A_STEP;
            count_o <= count_nxt_o;
        end
    end
endmodule

// File: rtl/s2m_err_hold.sv
module s2m_err_hold #(
    parameter int EW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          beat,
    input  logic [EW-1:0] err_in,
    output logic [EW-1:0] err_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     err_o <= '0;
        else if (clr)   err_o <= '0;
        else if (beat)  err_o <= err_o | err_in;
    end
endmodule

// File: rtl/s2m_irq_bank.sv
module s2m_irq_bank #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic         clr,
    output logic [N-1:0] irq
);
    for (genvar g = 0; g < N; g++) begin : g_irq
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      irq[g] <= 1'b0;
            else if (set[g]) irq[g] <= 1'b1;
            else if (clr)    irq[g] <= 1'b0;
        end
    end
endmodule

// File: rtl/s2m_write_engine.sv
module s2m_write_engine
    import s2m_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int LW = 16,
    parameter int EW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          desc_valid,
    output logic          desc_ready,
    input  logic [AW-1:0] desc_addr,
    input  logic [LW-1:0] desc_len,
    input  logic [31:0]   desc_ctrl,
    input  logic          st_valid,
    output logic          st_ready,
    input  logic [DW-1:0] st_data,
    input  logic          st_eop,
    input  logic [EW-1:0] st_err,
    output logic          mem_wr,
    input  logic          mem_wait,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic          done_pulse,
    output logic [LW-1:0] done_bytes,
    input  logic          irq_clr,
    output logic          irq_done,
    output logic          irq_err,
    output logic          irq_early
);
    localparam int STEP = DW / 8;

    state_t        state, state_nxt;
    logic          load, beat, last;
    logic [LW-1:0] len_q, count, count_nxt;
    logic          eop_mode_q, done_en_q, early_en_q, ovf_q;
    logic [EW-1:0] mask_q, err_rec;
    logic [IRQ_N-1:0] irq_set, irq_q;
    logic          unused_ctrl_bits;

    assign unused_ctrl_bits = ^{desc_ctrl[31:CTRL_MASK_LO+EW], desc_ctrl[13],
                                desc_ctrl[11:0]};

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // end-of-transfer decision
    always_comb begin
        if (eop_mode_q) last = st_eop;
        else            last = (count_nxt >= len_q);
    end

    // next state
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: if (desc_valid)  state_nxt = ST_RUN;   // LOAD
            ST_RUN:  if (beat && last) state_nxt = ST_DONE; // FINISH, else BEAT
            ST_DONE:                  state_nxt = ST_IDLE;  // RETIRE
            default:                  state_nxt = ST_IDLE;
        endcase
    end

    // outputs per state
    always_comb begin
        desc_ready = 1'b0;
        st_ready   = 1'b0;
        mem_wr     = 1'b0;
        done_pulse = 1'b0;
        irq_set    = '0;
        unique case (state)
            ST_IDLE: desc_ready = 1'b1;
            ST_RUN: begin
                st_ready = !mem_wait;
                mem_wr   = st_valid;
            end
            ST_DONE: begin
                done_pulse         = 1'b1;
                irq_set[IRQ_DONE]  = done_en_q;
                irq_set[IRQ_ERR]   = |(err_rec & mask_q);
                irq_set[IRQ_EARLY] = early_en_q && ovf_q;
            end
            default: ;
        endcase
    end

    assign load      = desc_ready && desc_valid;
    assign beat      = st_ready && st_valid;
    assign mem_wdata = st_data;

    // descriptor fields and overrun flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len_q      <= '0;
            eop_mode_q <= 1'b0;
            done_en_q  <= 1'b0;
            early_en_q <= 1'b0;
            mask_q     <= '0;
            ovf_q      <= 1'b0;
        end else if (load) begin
            len_q      <= desc_len;
            eop_mode_q <= desc_ctrl[CTRL_EOP_MODE];
            done_en_q  <= desc_ctrl[CTRL_DONE_EN];
            early_en_q <= desc_ctrl[CTRL_EARLY_EN];
            mask_q     <= desc_ctrl[CTRL_MASK_LO +: EW];
            ovf_q      <= 1'b0;
        end else if (beat && eop_mode_q && !st_eop && (count_nxt > len_q)) begin
            ovf_q      <= 1'b1;
        end
    end

    s2m_beat_track #(.AW(AW), .LW(LW), .STEP(STEP)) i_track (
        .clk(clk), .rst_n(rst_n), .load(load), .base(desc_addr), .beat(beat),
        .addr_o(mem_addr), .count_o(count), .count_nxt_o(count_nxt)
    );

    s2m_err_hold #(.EW(EW)) i_err (
        .clk(clk), .rst_n(rst_n), .clr(load), .beat(beat), .err_in(st_err),
        .err_o(err_rec)
    );

    s2m_irq_bank #(.N(IRQ_N)) i_irq (
        .clk(clk), .rst_n(rst_n), .set(irq_set), .clr(irq_clr), .irq(irq_q)
    );

    assign done_bytes = count;
    assign irq_done   = irq_q[IRQ_DONE];
    assign irq_err    = irq_q[IRQ_ERR];
    assign irq_early  = irq_q[IRQ_EARLY];
endmodule

// File: rtl/s2m_write_engine_chk.sv
module s2m_write_engine_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          desc_ready,
    input logic          st_ready,
    input logic          mem_wr,
    input logic          mem_wait,
    input logic [AW-1:0] mem_addr,
    input logic          done_pulse,
    input logic          irq_clr,
    input logic          irq_done,
    input logic          irq_err,
    input logic          irq_early
);
    // R2
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && !mem_wait) |=> (mem_addr == $past(mem_addr) + AW'(4)));

    // R5
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |=> !done_pulse);

    // R10
    idle_no_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        desc_ready |-> !st_ready);

    // R5
    done_after_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |=> desc_ready);

    // R9
    irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_clr && !done_pulse) |=> (!irq_done && !irq_err && !irq_early));

    // R9
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_done && !irq_clr) |=> irq_done);
endmodule

bind s2m_write_engine s2m_write_engine_chk #(.AW(AW)) i_chk (
    .clk(clk), .rst_n(rst_n), .desc_ready(desc_ready), .st_ready(st_ready),
    .mem_wr(mem_wr), .mem_wait(mem_wait), .mem_addr(mem_addr),
    .done_pulse(done_pulse), .irq_clr(irq_clr), .irq_done(irq_done),
    .irq_err(irq_err), .irq_early(irq_early)
);

// File: tb/test_s2m_write_engine.sv
module test_s2m_write_engine;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        desc_valid = 1'b0;
    logic        desc_ready;
    logic [31:0] desc_addr = '0;
    logic [15:0] desc_len = '0;
    logic [31:0] desc_ctrl = '0;
    logic        st_valid = 1'b0;
    logic        st_ready;
    logic [31:0] st_data = '0;
    logic        st_eop = 1'b0;
    logic [7:0]  st_err = '0;
    logic        mem_wr;
    logic        mem_wait = 1'b0;
    logic [31:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        done_pulse;
    logic [15:0] done_bytes;
    logic        irq_clr = 1'b0;
    logic        irq_done, irq_err, irq_early;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_P/2) clk = ~clk;

    s2m_write_engine i_s2m_write_engine (
        .clk(clk), .rst_n(rst_n), .desc_valid(desc_valid), .desc_ready(desc_ready),
        .desc_addr(desc_addr), .desc_len(desc_len), .desc_ctrl(desc_ctrl),
        .st_valid(st_valid), .st_ready(st_ready), .st_data(st_data), .st_eop(st_eop),
        .st_err(st_err), .mem_wr(mem_wr), .mem_wait(mem_wait), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .done_pulse(done_pulse), .done_bytes(done_bytes),
        .irq_clr(irq_clr), .irq_done(irq_done), .irq_err(irq_err), .irq_early(irq_early)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int beats_for_len(input int len);
        return (len == 0) ? 1 : (len + 3) / 4;
    endfunction

    function automatic logic early_exp(input logic pkt, input logic en, input int nb, input int len);
        return pkt && en && (4 * (nb - 1) > len);
    endfunction

    task automatic settle();
        #(CLK_P/4);
    endtask

    // one transfer; pkt_beats used in packet mode only
    task automatic xfer(input logic [31:0] base, input int len, input logic [31:0] ctrl,
                        input int pkt_beats, input logic clr_at_done);
        logic       pkt = ctrl[12];
        int         nb = pkt ? pkt_beats : beats_for_len(len);
        int         k = 0;
        logic [7:0] err_acc = '0;
        logic       ex_err, ex_early;
        @(negedge clk);
        desc_valid = 1'b1; desc_addr = base; desc_len = 16'(len); desc_ctrl = ctrl;
        settle();
        check("R10 desc_ready idle", {31'd0, desc_ready}, 32'd1);
        while (k < nb) begin
            @(negedge clk);
            desc_valid = ($urandom % 2) == 0;   // must be ignored while busy
            desc_addr  = $urandom;
            desc_len   = 16'($urandom);
            st_valid   = ($urandom % 10) < 7;
            mem_wait   = ($urandom % 4) == 0;
            st_data    = $urandom;
            st_err     = (($urandom % 6) == 0) ? 8'($urandom) : 8'h00;
            st_eop     = pkt ? (k == nb - 1) : (($urandom % 4) == 0);
            settle();
            check("R10 desc_ready busy", {31'd0, desc_ready}, 32'd0);
            check("R2 st_ready", {31'd0, st_ready}, {31'd0, !mem_wait});
            check("R2 mem_wr", {31'd0, mem_wr}, {31'd0, st_valid});
            if (st_valid && !mem_wait) begin
                check("R2 mem_addr", mem_addr, base + 32'(4 * k));
                check("R2 mem_wdata", mem_wdata, st_data);
                err_acc |= st_err;
                k++;
            end
        end
        @(negedge clk);
        desc_valid = 1'b0; st_valid = 1'b0; st_eop = 1'b0; mem_wait = 1'b0;
        irq_clr = clr_at_done;
        settle();
        check(pkt ? "R4 done on eop" : "R3 done on length", {31'd0, done_pulse}, 32'd1);
        check("R5 done_bytes", {16'd0, done_bytes}, 32'(4 * nb));
        @(negedge clk);
        irq_clr = 1'b0;
        settle();
        ex_err   = |(err_acc & ctrl[23:16]);
        ex_early = early_exp(pkt, ctrl[15], nb, len);
        check("R5 done one cycle", {31'd0, done_pulse}, 32'd0);
        check("R5 done_bytes held", {16'd0, done_bytes}, 32'(4 * nb));
        check("R7 irq_done", {31'd0, irq_done}, {31'd0, ctrl[14]});
        check("R6 irq_err", {31'd0, irq_err}, {31'd0, ex_err});
        check("R8 irq_early", {31'd0, irq_early}, {31'd0, ex_early});
        @(negedge clk);
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
        settle();
        check("R9 irq cleared", {29'd0, irq_done, irq_err, irq_early}, 32'd0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        settle();
        check("R1 desc_ready", {31'd0, desc_ready}, 32'd1);
        check("R1 st_ready", {31'd0, st_ready}, 32'd0);
        check("R1 mem_wr", {31'd0, mem_wr}, 32'd0);
        check("R1 done", {15'd0, done_pulse, done_bytes}, 32'd0);
        check("R1 irqs", {29'd0, irq_done, irq_err, irq_early}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // directed corners
        xfer(32'h1000_0000, 0,  32'h0000_4000, 0, 1'b0);           // R3 zero length -> one beat
        xfer(32'h2000_0100, 10, 32'h0000_C000, 0, 1'b0);           // R3 rounds up, R8 off in length mode
        xfer(32'h3000_0000, 16, 32'h0000_D000, 5, 1'b0);           // R8 eop beat alone crosses: no early
        xfer(32'h3000_1000, 16, 32'h0000_D000, 6, 1'b0);           // R8 overrun before eop
        xfer(32'h4000_0000, 64, 32'h0000_5000, 2, 1'b0);           // R4 short packet
        xfer(32'h5000_0000, 8,  32'hFFFF_4000, 3, 1'b1);           // R9 set wins over clear, R6 full mask

        // constrained random
        for (int t = 0; t < 60; t++) begin
            logic [31:0] ctl;
            ctl = {8'h00, 8'($urandom), ($urandom % 2 == 0), ($urandom % 2 == 0),
                   1'b0, ($urandom % 2 == 0), 12'($urandom)};
            xfer({$urandom, 2'b00} >> 2 << 2, int'($urandom % 48), ctl,
                 1 + int'($urandom % 20), 1'b0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule